// File: doc/BRIEF.md
# Wideband Input Level Monitor

This block watches a stream of signed input samples and reports how strong the signal is. The result can drive the gain or attenuation stage that sits ahead of the data converter. Each sample that arrives with its valid strobe is reduced to a magnitude. One of three detectors then folds that magnitude into a 32-bit accumulator. The integrating detector sums the magnitudes over a window. The leaky detector is a first-order low-pass filter whose coefficient is a power of two. The peak detector keeps the largest magnitude it has seen.

Software writes a configuration word (mode, leak coefficient, continuous flag, interval count) into a holding register. A start strobe copies that word into the working set and begins a new measurement. In window operation the measurement covers the programmed count plus two samples. At the end of the window the 32-bit result register is loaded and a done flag is raised. Reading the result clears the flag. The leaky and peak detectors can also run in stream operation: the result register then follows the accumulator after every sample and the measurement never ends by itself.

The controller is a state machine with three states. `ST_IDLE` waits for a start. `ST_WINDOW` runs a counted measurement. `ST_STREAM` runs a measurement that never ends by itself. The transitions are:
- **launch-window**: from `ST_IDLE`, or from either running state, on start when the held configuration does not ask for stream operation.
- **launch-stream**: on start when the held configuration asks for stream operation with the leaky or peak detector.
- **window-close**: from `ST_WINDOW` back to `ST_IDLE` on the last sample of the window.
- A start received in a running state restarts the measurement through the matching launch transition.

Top module: `sig_level_monitor`

## Requirements
- R1: After reset `done` is 0, `rd_data` is 0 and the block is idle.
- R2: A sample's magnitude is its absolute value; the most negative code gives the largest positive magnitude, 2^(SAMPLE_W-1)-1.
- R3: Mode code 00 (sum) adds the magnitudes of the window's samples into a 32-bit sum that starts at 0 and saturates at 2^32-1 instead of wrapping.
- R4: Mode code 01 (leaky) starts from Y=0 and updates Y <= Y + ((|x| << F) - Y) >>> k for each sample, where F = 32-(SAMPLE_W-1), `>>>` is an arithmetic shift that rounds toward minus infinity, and k is 8, 12 or 16 for leak codes 00, 01 and 10/11 respectively.
- R5: Mode codes 10 and 11 (peak) start from 0 and keep the largest magnitude seen.
- R6: With interval count N, a window holds N+2 valid samples. On the clock edge that takes the last of them, `rd_data` loads the final value, `done` goes to 1 and the block returns to idle.
- R7: Samples with `smp_valid` low, and samples that arrive while idle, change neither the accumulator nor `rd_data`.
- R8: A one-cycle `rd_en` clears `done` on the next edge and leaves `rd_data` unchanged; when a window closes in the same cycle, setting `done` wins.
- R9: With `cfg_cont`=1 in leaky or peak mode, `rd_data` takes the updated accumulator on the edge of every valid sample, and `done` never sets until a new start is given.
- R10: `cfg_cont` has no effect in sum mode; the measurement ends after N+2 samples.
- R11: `cfg_we` loads the holding registers. Only a start moves them into use, so a configuration write during a measurement does not change that measurement.
- R12: A start during a measurement clears the accumulator, the sample count and `done`, and begins again with the held configuration. Samples in the start cycle are not counted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Load the holding configuration |
| cfg_mode | input | 2 | Detector: 00 sum, 01 leaky, 10/11 peak |
| cfg_leak | input | 2 | Leak shift: 00 k=8, 01 k=12, 10/11 k=16 |
| cfg_cont | input | 1 | Stream operation (leaky and peak only) |
| cfg_count | input | COUNT_W | Interval count N; window is N+2 samples |
| start | input | 1 | Start or restart a measurement |
| smp_valid | input | 1 | Sample strobe |
| smp_data | input | SAMPLE_W | Signed two's-complement sample |
| rd_en | input | 1 | Result read strobe, clears done |
| rd_data | output | RESULT_W | Result register |
| done | output | 1 | Window measurement complete |

## Verification
A wrong internal state shows up as a wrong `rd_data` value at the edge where a window closes. It can also show up as `done` rising one sample early or late, because the bench samples the flag on the exact cycle after the last valid sample. In stream operation an accumulator fault is visible at the ports one cycle after the faulty sample, since `rd_data` follows every update. A start or configuration write that is handled wrongly mixes state between measurements. The bench exposes this by comparing against a sum, filter or peak model that it recomputes from scratch for each stimulus.

// File: rtl/lvl_pkg.sv
package lvl_pkg;

    typedef enum logic [1:0] {
        MODE_SUM  = 2'd0,
        MODE_LEAK = 2'd1,
        MODE_PEAK = 2'd2
    } det_mode_e;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_WINDOW = 2'd1,
        ST_STREAM = 2'd2
    } ctl_state_e;

    // number of selectable leak shifts; shift = LEAK_BASE + LEAK_STEP*index
    localparam int LEAK_OPTS = 3;
    localparam int LEAK_BASE = 8;
    localparam int LEAK_STEP = 4;

    typedef struct packed {
        det_mode_e  mode;
        logic [1:0] leak;
        logic       cont;
    } det_cfg_t;

    function automatic det_mode_e decode_mode(input logic [1:0] code);
        unique case (code)
            2'd0:    return MODE_SUM;
            2'd1:    return MODE_LEAK;
            default: return MODE_PEAK;
        endcase
    endfunction

endpackage

// File: rtl/lvl_mag.sv
module lvl_mag #(
    parameter int SW = 16,
    localparam int MW = SW - 1
) (
    input  logic [SW-1:0] sample_i,
    output logic [MW-1:0] mag_o
);

    logic [SW-1:0] neg_w;

    always_comb begin
        neg_w = ~sample_i + {{(SW-1){1'b0}}, 1'b1};
        if (!sample_i[SW-1]) begin
            mag_o = sample_i[MW-1:0];
        end else if (neg_w[SW-1]) begin
            // only the most negative code negates to itself
            mag_o = {MW{1'b1}};
        end else begin
            mag_o = neg_w[MW-1:0];
        end
    end

endmodule

// File: rtl/lvl_accum.sv
module lvl_accum
    import lvl_pkg::*;
#(
    parameter int MW = 15,
    parameter int RW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clear_i,
    input  logic          en_i,
    input  det_mode_e     mode_i,
    input  logic [1:0]    leak_i,
    input  logic [MW-1:0] mag_i,
    output logic [RW-1:0] acc_o,
    output logic [RW-1:0] nxt_o
);

    localparam int FW = RW - MW;

    logic [RW-1:0]        acc_q;
    logic [RW:0]          sum_w;
    logic [RW-1:0]        tgt_w;
    logic [RW-1:0]        pk_w;
    logic signed [RW:0]   diff_w;
    logic signed [RW:0]   step_opt [LEAK_OPTS];
    logic signed [RW:0]   step_sel;

    generate
        for (genvar g = 0; g < LEAK_OPTS; g++) begin : g_leak
            assign step_opt[g] = diff_w >>> (LEAK_BASE + LEAK_STEP * g);
        end
    endgenerate

    always_comb begin
        sum_w  = {1'b0, acc_q} + {{(RW + 1 - MW){1'b0}}, mag_i};
        tgt_w  = {mag_i, {FW{1'b0}}};
        pk_w   = {{FW{1'b0}}, mag_i};
        diff_w = $signed({1'b0, tgt_w}) - $signed({1'b0, acc_q});
        unique case (leak_i)
            2'd0:    step_sel = step_opt[0];
            2'd1:    step_sel = step_opt[1];
            default: step_sel = step_opt[2];
        endcase
        unique case (mode_i)
            MODE_SUM:  nxt_o = sum_w[RW] ? {RW{1'b1}} : sum_w[RW-1:0];
            MODE_LEAK: nxt_o = acc_q + step_sel[RW-1:0];
            MODE_PEAK: nxt_o = (pk_w > acc_q) ? pk_w : acc_q;
            default:   nxt_o = acc_q;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc_q <= '0;
        end else if (clear_i) begin
            acc_q <= '0;
        end else if (en_i) begin
            acc_q <= nxt_o;
        end
    end

    assign acc_o = acc_q;

endmodule

// File: rtl/lvl_ctrl.sv
module lvl_ctrl
    import lvl_pkg::*;
#(
    parameter int CW = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start_i,
    input  logic         smp_valid_i,
    input  logic         arm_stream_i,
    input  logic [CW-1:0] limit_i,
    output ctl_state_e   state_o,
    output logic         acc_clear_o,
    output logic         acc_en_o,
    output logic         capture_o,
    output logic         last_o,
    output logic [CW:0]  cnt_o
);

    ctl_state_e  state_q;
    ctl_state_e  state_d;
    logic [CW:0] cnt_q;
    logic [CW:0] final_idx;

    assign final_idx = {1'b0, limit_i} + {{CW{1'b0}}, 1'b1};

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        if (start_i) begin
            state_d = arm_stream_i ? ST_STREAM : ST_WINDOW;
        end else begin
            unique case (state_q)
                ST_IDLE:   state_d = ST_IDLE;
                ST_WINDOW: if (last_o) state_d = ST_IDLE;
                ST_STREAM: state_d = ST_STREAM;
                default:   state_d = ST_IDLE;
            endcase
        end
    end

    // outputs
    always_comb begin
        acc_clear_o = start_i;
        acc_en_o    = 1'b0;
        last_o      = 1'b0;
        capture_o   = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                acc_en_o = 1'b0;
            end
            ST_WINDOW: begin
                acc_en_o  = smp_valid_i && !start_i;
                last_o    = acc_en_o && (cnt_q == final_idx);
                capture_o = last_o;
            end
            ST_STREAM: begin
                acc_en_o  = smp_valid_i && !start_i;
                capture_o = acc_en_o;
            end
            default: begin
                acc_en_o = 1'b0;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (start_i) begin
            cnt_q <= '0;
        end else if (acc_en_o && state_q == ST_WINDOW) begin
            cnt_q <= cnt_q + {{CW{1'b0}}, 1'b1};
        end
    end

    assign state_o = state_q;
    assign cnt_o   = cnt_q;

endmodule

// File: rtl/sig_level_monitor.sv
module sig_level_monitor
    import lvl_pkg::*;
#(
    parameter int SAMPLE_W = 16,
    parameter int RESULT_W = 32,
    parameter int COUNT_W  = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cfg_we,
    input  logic [1:0]          cfg_mode,
    input  logic [1:0]          cfg_leak,
    input  logic                cfg_cont,
    input  logic [COUNT_W-1:0]  cfg_count,
    input  logic                start,
    input  logic                smp_valid,
    input  logic [SAMPLE_W-1:0] smp_data,
    input  logic                rd_en,
    output logic [RESULT_W-1:0] rd_data,
    output logic                done
);

    localparam int MAG_W = SAMPLE_W - 1;

    det_cfg_t            shd_cfg;
    det_cfg_t            act_cfg;
    logic [COUNT_W-1:0]  shd_count;
    logic [COUNT_W-1:0]  act_count;
    logic [MAG_W-1:0]    mag;
    logic [RESULT_W-1:0] acc_q;
    logic [RESULT_W-1:0] acc_nxt;
    logic [RESULT_W-1:0] result_q;
    logic                done_q;
    logic                arm_stream;
    ctl_state_e          ctl_state;
    logic                acc_clear;
    logic                acc_en;
    logic                capture;
    logic                win_last;
    logic [COUNT_W:0]    ctl_cnt;

    assign arm_stream = shd_cfg.cont && (shd_cfg.mode != MODE_SUM);

    // holding and working configuration
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shd_cfg   <= '{mode: MODE_SUM, leak: 2'd0, cont: 1'b0};
            shd_count <= '0;
            act_cfg   <= '{mode: MODE_SUM, leak: 2'd0, cont: 1'b0};
            act_count <= '0;
        end else begin
            if (cfg_we) begin
                shd_cfg   <= '{mode: decode_mode(cfg_mode), leak: cfg_leak, cont: cfg_cont};
                shd_count <= cfg_count;
            end
            if (start) begin
                act_cfg   <= shd_cfg;
                act_count <= shd_count;
            end
        end
    end

    lvl_mag #(
        .SW(SAMPLE_W)
    ) mag_i (
        .sample_i(smp_data),
        .mag_o   (mag)
    );

    lvl_ctrl #(
        .CW(COUNT_W)
    ) ctrl_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_i     (start),
        .smp_valid_i (smp_valid),
        .arm_stream_i(arm_stream),
        .limit_i     (act_count),
        .state_o     (ctl_state),
        .acc_clear_o (acc_clear),
        .acc_en_o    (acc_en),
        .capture_o   (capture),
        .last_o      (win_last),
        .cnt_o       (ctl_cnt)
    );

    lvl_accum #(
        .MW(MAG_W),
        .RW(RESULT_W)
    ) accum_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .clear_i(acc_clear),
        .en_i   (acc_en),
        .mode_i (act_cfg.mode),
        .leak_i (act_cfg.leak),
        .mag_i  (mag),
        .acc_o  (acc_q),
        .nxt_o  (acc_nxt)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            result_q <= '0;
            done_q   <= 1'b0;
        end else begin
            if (capture) begin
                result_q <= acc_nxt;
            end
            if (win_last) begin
                done_q <= 1'b1;
            end else if (rd_en || start) begin
                done_q <= 1'b0;
            end
        end
    end

    assign rd_data = result_q;
    assign done    = done_q;

endmodule

// File: rtl/lvl_chk.sv
module lvl_chk
    import lvl_pkg::*;
#(
    parameter int RW = 32,
    parameter int CW = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic          start,
    input logic          rd_en,
    input logic          smp_valid,
    input logic          done,
    input logic [RW-1:0] result,
    input logic [RW-1:0] acc,
    input ctl_state_e    state,
    input det_mode_e     mode,
    input logic [CW:0]   cnt,
    input logic [CW-1:0] lim
);

    // R6
    done_rise_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> $past(state == ST_WINDOW));

    // R6
    count_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_WINDOW) |-> (cnt <= ({1'b0, lim} + 1'b1)));

    // R8
    done_fall_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(done) |-> $past(rd_en || start));

    // R5
    peak_monotone_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_IDLE && mode == MODE_PEAK && !start) |=> (acc >= $past(acc)));

    // R3
    sum_monotone_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_IDLE && mode == MODE_SUM && !start) |=> (acc >= $past(acc)));

    // R9
    stream_tracks_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_STREAM && smp_valid && !start) |=> (result == acc));

    // R9
    stream_no_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_STREAM && !start) |=> !$rose(done));

    // R7
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && !start) |=> $stable(result));

endmodule

bind sig_level_monitor lvl_chk #(
    .RW(RESULT_W),
    .CW(COUNT_W)
) chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .rd_en    (rd_en),
    .smp_valid(smp_valid),
    .done     (done),
    .result   (rd_data),
    .acc      (acc_q),
    .state    (ctl_state),
    .mode     (act_cfg.mode),
    .cnt      (ctl_cnt),
    .lim      (act_count)
);

// File: tb/sig_level_monitor_tb_top.sv
module sig_level_monitor_tb_top;

    localparam int SW = 18;
    localparam int RW = 32;
    localparam int CW = 16;
    localparam int FB = RW - (SW - 1);

    typedef struct packed {
        logic [1:0]           mode;
        logic [1:0]           leak;
        logic [15:0]          n;
        logic signed [SW-1:0] base;
        logic signed [SW-1:0] step;
        logic                 gap;
    } vec_t;

    localparam int NV = 8;
    localparam vec_t VECS [NV] = '{
        '{2'd0, 2'd0, 16'd0,  18'sd100,     18'sd50,   1'b0},
        '{2'd0, 2'd0, 16'd5,  -18'sd300,    18'sd97,   1'b1},
        '{2'd1, 2'd0, 16'd40, 18'sd5000,    18'sd0,    1'b0},
        '{2'd1, 2'd1, 16'd30, -18'sd20000,  18'sd1000, 1'b1},
        '{2'd1, 2'd3, 16'd10, 18'sd131071,  -18'sd7,   1'b0},
        '{2'd2, 2'd0, 16'd6,  -18'sd131072, 18'sd3,    1'b0},
        '{2'd3, 2'd0, 16'd20, -18'sd50,     18'sd9,    1'b1},
        '{2'd0, 2'd0, 16'd3,  -18'sd131072, 18'sd0,    1'b0}
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cfg_we = 1'b0;
    logic [1:0]    cfg_mode = '0;
    logic [1:0]    cfg_leak = '0;
    logic          cfg_cont = 1'b0;
    logic [CW-1:0] cfg_count = '0;
    logic          start = 1'b0;
    logic          smp_valid = 1'b0;
    logic [SW-1:0] smp_data = '0;
    logic          rd_en = 1'b0;
    logic [RW-1:0] rd_data;
    logic          done;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    sig_level_monitor #(
        .SAMPLE_W(SW),
        .RESULT_W(RW),
        .COUNT_W (CW)
    ) dut_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .cfg_we   (cfg_we),
        .cfg_mode (cfg_mode),
        .cfg_leak (cfg_leak),
        .cfg_cont (cfg_cont),
        .cfg_count(cfg_count),
        .start    (start),
        .smp_valid(smp_valid),
        .smp_data (smp_data),
        .rd_en    (rd_en),
        .rd_data  (rd_data),
        .done     (done)
    );

    task automatic chk(input string tag, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic longint wrap_s(input longint v);
        logic signed [SW-1:0] t;
        t = v[SW-1:0];
        return longint'(t);
    endfunction

    function automatic longint mag_of(input longint x);
        if (x == -(longint'(1) <<< (SW - 1))) return (longint'(1) <<< (SW - 1)) - 1;
        return (x < 0) ? -x : x;
    endfunction

    function automatic longint model(input int mode, input int leak, input int n,
                                     input longint base, input longint step);
        longint y = 0;
        for (int k = 0; k < n + 2; k++) begin
            longint m = mag_of(wrap_s(base + k * step));
            if (mode == 0) begin
                y = y + m;
                if (y > 64'hFFFF_FFFF) y = 64'hFFFF_FFFF;
            end else if (mode == 1) begin
                int sh = (leak >= 2) ? 16 : 8 + 4 * leak;
                longint d = (m <<< FB) - y;
                y = y + (d >>> sh);
            end else begin
                if (m > y) y = m;
            end
        end
        return y;
    endfunction

    // all tasks start and end at a falling edge
    task automatic cfg_write(input int mode, input int leak, input bit cont, input int n);
        cfg_we = 1'b1; cfg_mode = mode[1:0]; cfg_leak = leak[1:0];
        cfg_cont = cont; cfg_count = n[CW-1:0];
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic pulse_start();
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic put(input longint x);
        smp_valid = 1'b1; smp_data = x[SW-1:0];
        @(negedge clk);
        smp_valid = 1'b0;
    endtask

    task automatic pulse_read();
        rd_en = 1'b1;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [RW-1:0] held;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 done after reset", done, 0);
        chk("R1 rd_data after reset", rd_data, 0);
        put(1234);
        put(-99);
        chk("R7 idle samples ignored", rd_data, 0);

        for (int v = 0; v < NV; v++) begin
            longint exp;
            string tag;
            exp = model(VECS[v].mode, VECS[v].leak, VECS[v].n, VECS[v].base, VECS[v].step);
            tag = (VECS[v].mode == 0) ? "R3/R2 sum" : (VECS[v].mode == 1) ? "R4 leaky" : "R5/R2 peak";
            cfg_write(VECS[v].mode, VECS[v].leak, 1'b0, VECS[v].n);
            pulse_start();
            for (int k = 0; k < VECS[v].n + 2; k++) begin
                if (k == VECS[v].n + 1) chk("R6 done not early", done, 0);
                put(wrap_s(VECS[v].base + k * VECS[v].step));
                if (VECS[v].gap) @(negedge clk);
            end
            chk(tag, rd_data, exp);
            chk("R6 done at window end", done, 1);
            put(7777);
            put(-7777);
            chk("R7 samples after window ignored", rd_data, exp);
            pulse_read();
            chk("R8 read clears done", done, 0);
            chk("R8 read keeps result", rd_data, exp);
        end

        // R9 stream peak
        cfg_write(2, 0, 1'b1, 0);
        pulse_start();
        put(10);  chk("R9 stream peak 1", rd_data, 10);
        put(-40); chk("R9 stream peak 2", rd_data, 40);
        put(20);  chk("R9 stream peak 3", rd_data, 40);
        chk("R9 stream no done", done, 0);

        // R9 stream leaky, restart from the peak stream (R12)
        cfg_write(1, 0, 1'b1, 0);
        pulse_start();
        put(1000);
        chk("R9 stream leaky", rd_data, (longint'(1000) <<< FB) >>> 8);
        chk("R9 stream leaky no done", done, 0);

        // R10 continuous flag ignored in sum mode
        cfg_write(0, 0, 1'b1, 1);
        pulse_start();
        put(7); put(7);
        chk("R10 not done after two", done, 0);
        put(7);
        chk("R10 sum ends", done, 1);
        chk("R10 sum value", rd_data, 21);
        pulse_read();

        // R11 config write during a measurement
        cfg_write(0, 0, 1'b0, 2);
        pulse_start();
        put(5);
        cfg_write(2, 0, 1'b0, 0);
        put(5); put(5);
        chk("R11 window unchanged", done, 0);
        put(5);
        chk("R11 done", done, 1);
        chk("R11 sum kept", rd_data, 20);
        pulse_read();

        // R12 restart mid-window
        cfg_write(0, 0, 1'b0, 3);
        pulse_start();
        put(1000); put(1000);
        pulse_start();
        for (int k = 0; k < 5; k++) put(10);
        chk("R12 restart sum", rd_data, 50);
        chk("R12 restart done", done, 1);
        held = rd_data;
        pulse_start();
        chk("R12 start clears done", done, 0);
        chk("R12 start keeps result", rd_data, held);

        // R3 saturation at the largest interval
        cfg_write(0, 0, 1'b0, 65535);
        pulse_start();
        for (int k = 0; k < 65536; k++) put(131071);
        chk("R6 max window not early", done, 0);
        put(131071);
        chk("R3 saturated sum", rd_data, 64'hFFFF_FFFF);
        chk("R6 max window done", done, 1);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule